// File: doc/BRIEF.md
# Station Management Master (Clause 22 / Clause 45)

This block is the master side of a two-wire station management link. It generates the management clock and drives a bidirectional data line (split here into value, enable and input pins) to read and write registers in one or more managed devices. A host presents one command through a four-phase request/acknowledge exchange. The command holds a clause select, a 2-bit opcode, a 5-bit port address, a 5-bit register or device-type field, a 16-bit register address used in the extended clause, 16 bits of write data and an address-first flag. The block serializes the frame, hands the line over for the turnaround on reads, and collects the 16 returned bits.

In the basic clause a command becomes one frame. In the extended clause the 5-bit field names a device type. The register address then travels in a separate address frame. When the host asks for it, the block sends that address frame and the operation frame back to back without returning to the host. A read-with-increment command can leave the flag clear, so that repeated reads walk through consecutive registers without re-addressing.

The controller moves through these states: IDLE waits for a request. PREAMBLE drives the run of ones. HEADER sends the start code, opcode, both address fields and the turnaround. DATA moves the 16-bit field. NEXT decides between a queued second frame (back to PREAMBLE) and completion (to ACK). ACK holds the acknowledge until the host drops its request, then returns to IDLE.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc` is low, `mdio_oe` is low, `cmd_ack` and `busy` are low and `rd_data` is zero. Whenever `busy` is low, `mdc` stays low and the line is released.
- R2: Each MDC low and high phase lasts HALF clock cycles, with HALF = ceil(CLK_HZ / (2 * MDC_MAX_HZ)). With the defaults this gives 20 cycles and 2.5 MHz.
- R3: Every frame starts with 32 consecutive 1 bits, driven by the master.
- R4: After the preamble the master sends these fields most-significant bit first: a 2-bit start code (01 basic clause, 00 extended clause), the 2-bit opcode, the 5-bit `cmd_phy`, the 5-bit `cmd_dev`, 2 turnaround bits, and a 16-bit data field. Each frame therefore spans exactly 64 MDC cycles.
- R5: In a non-read frame, the master drives the turnaround as 1 then 0. It drives the data field with `cmd_wdata`, or with `cmd_reg` in an address frame.
- R6: Read frames are basic-clause opcode 10 and extended-clause opcodes 11 and 10. In a read frame the master releases the line (`mdio_oe` = 0) for both turnaround bits and all 16 data bits.
- R7: In a read frame, `mdio_i` is sampled at each MDC rising edge of the data field, first bit into the MSB. The 16 bits appear on `rd_data` by the time `cmd_ack` rises. A command with no read frame leaves `rd_data` unchanged.
- R8: With `cmd_c45` = 1, opcode 00 sends one address frame carrying `cmd_reg`. With `cmd_c45` = 1, any other opcode and `cmd_addr_first` = 1, the block sends an address frame (opcode 00, data `cmd_reg`) and then the operation frame with the same port and device fields. With `cmd_addr_first` = 0, it sends only the operation frame.
- R9: A request is taken when `cmd_req` is high in IDLE, and `busy` is high from the next cycle until the transfer ends. `cmd_ack` then stays high, with `busy` low and MDC stopped, for as long as `cmd_req` stays high. The cycle after `cmd_req` drops, `cmd_ack` is low.
- R10: `mdio_o` and `mdio_oe` change only at an MDC falling edge or while MDC is low, never during the high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_req | input | 1 | Command request, held until acknowledged |
| cmd_c45 | input | 1 | 1 selects the extended clause, 0 the basic clause |
| cmd_op | input | 2 | Opcode |
| cmd_phy | input | 5 | Port address |
| cmd_dev | input | 5 | Register address (basic) or device type (extended) |
| cmd_reg | input | 16 | Register address carried by an extended address frame |
| cmd_wdata | input | 16 | Write data |
| cmd_addr_first | input | 1 | Precede an extended operation with an address frame |
| cmd_ack | output | 1 | Command complete, held until `cmd_req` falls |
| busy | output | 1 | Transfer in progress |
| rd_data | output | 16 | Last word read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line as observed |

## Verification
The assertions assume that the host keeps `cmd_req` high until it sees `cmd_ack`, and holds the command fields steady while the request is pending. They also assume that `mdio_i` changes only while MDC is low. The stimulus follows these rules: every command is raised at a falling clock edge and held until the acknowledge appears. The simulated managed device updates `mdio_i` just after each MDC falling edge. The random commands draw basic-clause opcodes only from the two defined ones, so every frame has a specified drive pattern.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int DATA_W = 16;
    localparam int ADR_W  = 5;

    localparam logic [1:0] START_BASIC = 2'b01;
    localparam logic [1:0] START_EXT   = 2'b00;
    localparam logic [1:0] OP_EXT_ADDR = 2'b00;
    localparam logic [1:0] TA_DRIVEN   = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_DATA,
        ST_NEXT,
        ST_ACK
    } mgmt_state_t;

    function automatic logic op_is_read(input logic ext, input logic [1:0] op);
        return ext ? op[1] : (op == 2'b10);
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int HALF = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          term;

    assign term = (cnt == CW'(HALF - 1));
    assign rise = run && term && !mdc;
    assign fall = run && term && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (term) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/mdio_hdr_build.sv
module mdio_hdr_build
    import mdio_pkg::*;
(
    input  logic             ext,
    input  logic [1:0]       op,
    input  logic [ADR_W-1:0] phy,
    input  logic [ADR_W-1:0] dev,
    output logic [15:0]      hdr
);
    always_comb begin
        hdr = {(ext ? START_EXT : START_BASIC), op, phy, dev, TA_DRIVEN};
    end
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int MDC_MAX_HZ = 2_500_000,
    parameter int PRE_BITS   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_req,
    input  logic              cmd_c45,
    input  logic [1:0]        cmd_op,
    input  logic [ADR_W-1:0]  cmd_phy,
    input  logic [ADR_W-1:0]  cmd_dev,
    input  logic [DATA_W-1:0] cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_addr_first,
    output logic              cmd_ack,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int HALF    = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);
    localparam int CNT_MAX = (PRE_BITS > DATA_W) ? PRE_BITS : DATA_W;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam int HDR_BITS = 16;
    localparam int TA_POS   = HDR_BITS - 2;

    mgmt_state_t state, state_nx;

    logic [CNT_W-1:0]  bit_cnt;
    logic [15:0]       hdr_sr;
    logic [DATA_W-1:0] dat_sr;
    logic              cur_rd;
    logic              pend;

    logic              lat_c45, lat_af;
    logic [1:0]        lat_op;
    logic [ADR_W-1:0]  lat_phy, lat_dev;
    logic [DATA_W-1:0] lat_wdata;

    logic              run, rise, fall;

    // Parameters of the frame about to be loaded (first frame in IDLE, queued frame in NEXT)
    logic              in_idle;
    logic              sel_c45;
    logic [1:0]        sel_op;
    logic [ADR_W-1:0]  sel_phy, sel_dev;
    logic              first_addr;
    logic [1:0]        f_op;
    logic [DATA_W-1:0] f_data;
    logic              f_rd;
    logic              f_pend;
    logic [15:0]       hdr_w;

    assign in_idle = (state == ST_IDLE);
    assign sel_c45 = in_idle ? cmd_c45 : lat_c45;
    assign sel_op  = in_idle ? cmd_op  : lat_op;
    assign sel_phy = in_idle ? cmd_phy : lat_phy;
    assign sel_dev = in_idle ? cmd_dev : lat_dev;

    always_comb begin
        first_addr = in_idle && cmd_c45 && ((cmd_op == OP_EXT_ADDR) || cmd_addr_first);
        f_op   = first_addr ? OP_EXT_ADDR : sel_op;
        f_data = first_addr ? cmd_reg : (in_idle ? cmd_wdata : lat_wdata);
        f_rd   = first_addr ? 1'b0 : op_is_read(sel_c45, sel_op);
        f_pend = in_idle && cmd_c45 && (cmd_op != OP_EXT_ADDR) && cmd_addr_first;
    end

    mdio_hdr_build u_hdr (
        .ext (sel_c45),
        .op  (f_op),
        .phy (sel_phy),
        .dev (sel_dev),
        .hdr (hdr_w)
    );

    mdio_clkdiv #(.HALF(HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_rx_shift #(.W(DATA_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    ((state == ST_DATA) && rise && cur_rd),
        .din   (mdio_i),
        .q     (rd_data)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (cmd_req) state_nx = ST_PREAMBLE;
            ST_PREAMBLE: if (fall && bit_cnt == CNT_W'(PRE_BITS - 1)) state_nx = ST_HEADER;
            ST_HEADER:   if (fall && bit_cnt == CNT_W'(HDR_BITS - 1)) state_nx = ST_DATA;
            ST_DATA:     if (fall && bit_cnt == CNT_W'(DATA_W - 1)) state_nx = ST_NEXT;
            ST_NEXT:     state_nx = pend ? ST_PREAMBLE : ST_ACK;
            ST_ACK:      if (!cmd_req) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            hdr_sr    <= '0;
            dat_sr    <= '0;
            cur_rd    <= 1'b0;
            pend      <= 1'b0;
            lat_c45   <= 1'b0;
            lat_af    <= 1'b0;
            lat_op    <= '0;
            lat_phy   <= '0;
            lat_dev   <= '0;
            lat_wdata <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: if (cmd_req) begin
                    lat_c45   <= cmd_c45;
                    lat_af    <= cmd_addr_first;
                    lat_op    <= cmd_op;
                    lat_phy   <= cmd_phy;
                    lat_dev   <= cmd_dev;
                    lat_wdata <= cmd_wdata;
                    hdr_sr    <= hdr_w;
                    dat_sr    <= f_data;
                    cur_rd    <= f_rd;
                    pend      <= f_pend;
                    bit_cnt   <= '0;
                end
                ST_PREAMBLE: if (fall) begin
                    bit_cnt <= (bit_cnt == CNT_W'(PRE_BITS - 1)) ? '0 : bit_cnt + CNT_W'(1);
                end
                ST_HEADER: if (fall) begin
                    hdr_sr  <= {hdr_sr[14:0], 1'b0};
                    bit_cnt <= (bit_cnt == CNT_W'(HDR_BITS - 1)) ? '0 : bit_cnt + CNT_W'(1);
                end
                ST_DATA: if (fall) begin
                    dat_sr  <= {dat_sr[DATA_W-2:0], 1'b0};
                    bit_cnt <= (bit_cnt == CNT_W'(DATA_W - 1)) ? '0 : bit_cnt + CNT_W'(1);
                end
                ST_NEXT: if (pend) begin
                    hdr_sr  <= hdr_w;
                    dat_sr  <= f_data;
                    cur_rd  <= f_rd;
                    pend    <= 1'b0;
                    bit_cnt <= '0;
                end
                ST_ACK: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        run     = 1'b0;
        busy    = 1'b0;
        cmd_ack = 1'b0;
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PREAMBLE: begin
                run = 1'b1; busy = 1'b1;
                mdio_o = 1'b1; mdio_oe = 1'b1;
            end
            ST_HEADER: begin
                run = 1'b1; busy = 1'b1;
                mdio_o  = hdr_sr[15];
                mdio_oe = !(cur_rd && (bit_cnt >= CNT_W'(TA_POS)));
            end
            ST_DATA: begin
                run = 1'b1; busy = 1'b1;
                mdio_o  = dat_sr[DATA_W-1];
                mdio_oe = !cur_rd;
            end
            ST_NEXT: busy = 1'b1;
            ST_ACK:  cmd_ack = 1'b1;
            default: ;
        endcase
    end

    logic unused_lat_af;
    assign unused_lat_af = lat_af;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int CLK_HZ     = 100_000_000,
    parameter int MDC_MAX_HZ = 2_500_000
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_req,
    input logic cmd_ack,
    input logic busy,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    localparam int HALF = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);

    int hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hi_cnt <= 0;
        else if (mdc) hi_cnt <= hi_cnt + 1;
        else          hi_cnt <= 0;
    end

    a_r2_mdc_high_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> (hi_cnt < HALF));

    a_r1_quiet_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    a_r1_quiet_line_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    a_r9_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ack && cmd_req) |=> cmd_ack);

    a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ack && !cmd_req) |=> (!cmd_ack && !busy));

    a_r9_ack_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ack && busy));

    a_r10_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

bind mdio_master mdio_master_chk #(
    .CLK_HZ     (CLK_HZ),
    .MDC_MAX_HZ (MDC_MAX_HZ)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_req (cmd_req),
    .cmd_ack (cmd_ack),
    .busy    (busy),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int TB_CLK_HZ = 100_000_000;
    localparam int TB_MDC_HZ = 25_000_000;
    localparam int EXP_HALF  = (TB_CLK_HZ + 2 * TB_MDC_HZ - 1) / (2 * TB_MDC_HZ);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_req = 1'b0;
    logic        cmd_c45 = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_dev = '0;
    logic [15:0] cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic        cmd_addr_first = 1'b0;
    logic        cmd_ack, busy, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    int errors = 0;
    int checks = 0;

    logic [15:0] slave_word = '0;
    logic [15:0] exp_rd = '0;
    logic        cap_oe [0:127];
    logic        cap_o  [0:127];
    int          ncap = 0;
    int          hi_run = 0;
    int          hi_min = 1000;
    int          hi_max = 0;

    always #5 clk = ~clk;

    mdio_master #(.CLK_HZ(TB_CLK_HZ), .MDC_MAX_HZ(TB_MDC_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_c45(cmd_c45),
        .cmd_op(cmd_op), .cmd_phy(cmd_phy), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
        .cmd_wdata(cmd_wdata), .cmd_addr_first(cmd_addr_first), .cmd_ack(cmd_ack),
        .busy(busy), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Line monitor: record the master's drive at each MDC rising edge
    initial forever begin
        @(posedge mdc);
        #1;
        if (ncap < 128) begin
            cap_oe[ncap] = mdio_oe;
            cap_o[ncap]  = mdio_o;
        end
        ncap = ncap + 1;
    end

    // Managed device model: present read data after each MDC falling edge
    initial forever begin
        @(negedge mdc);
        #1;
        if ((ncap % 64) >= 48) mdio_i = slave_word[63 - (ncap % 64)];
        else                   mdio_i = 1'b1;
    end

    // MDC high-phase length monitor (R2)
    always @(negedge clk) begin
        if (mdc) hi_run = hi_run + 1;
        else if (hi_run != 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic is_rd(input logic ext, input logic [1:0] op);
        return ext ? op[1] : (op == 2'b10);
    endfunction

    function automatic logic [63:0] frame_val(input logic ext, input logic [1:0] op,
            input logic [4:0] phy, input logic [4:0] dev, input logic [15:0] d);
        return {32'hFFFF_FFFF, (ext ? 2'b00 : 2'b01), op, phy, dev, 2'b10, d};
    endfunction

    function automatic logic [63:0] frame_oe(input logic rd);
        return rd ? ~64'h3FFFF : ~64'h0;
    endfunction

    task automatic run_cmd(input logic ext, input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] dev, input logic [15:0] rg, input logic [15:0] wd,
                           input logic af, input logic [15:0] sw);
        logic        fa;
        int          nf;
        logic [1:0]  fop;
        logic [15:0] fdat;
        logic        frd;
        logic        any_rd;
        logic [63:0] ev, eo, av, ao;
        int          bad;
        string       tag;

        @(negedge clk);
        slave_word = sw;
        ncap = 0;
        cmd_c45 = ext; cmd_op = op; cmd_phy = phy; cmd_dev = dev;
        cmd_reg = rg; cmd_wdata = wd; cmd_addr_first = af;
        cmd_req = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R9", "busy after accept", {63'd0, busy}, 64'd1);
        while (!cmd_ack) @(negedge clk);

        fa = ext && ((op == 2'b00) || af);
        nf = (ext && (op != 2'b00) && af) ? 2 : 1;
        check(ncap == 64 * nf, "R8", "MDC cycles per command", 64'(ncap), 64'(64 * nf));

        any_rd = 1'b0;
        for (int f = 0; f < nf; f++) begin
            if (f == 0 && fa) begin fop = 2'b00; fdat = rg; frd = 1'b0; end
            else begin fop = op; fdat = wd; frd = is_rd(ext, op); end
            if (frd) any_rd = 1'b1;
            ev = frame_val(ext, fop, phy, dev, fdat);
            eo = frame_oe(frd);
            av = '0; ao = '0;
            bad = -1;
            for (int k = 0; k < 64; k++) begin
                if (64 * f + k < 128 && 64 * f + k < ncap) begin
                    av[63 - k] = cap_o[64 * f + k];
                    ao[63 - k] = cap_oe[64 * f + k];
                end
                if (bad < 0 && (ao[63 - k] !== eo[63 - k] ||
                                (eo[63 - k] && av[63 - k] !== ev[63 - k]))) bad = k;
            end
            if (bad < 0)       tag = "R4";
            else if (bad < 32) tag = "R3";
            else if (bad < 46) tag = "R4";
            else if (frd)      tag = "R6";
            else               tag = "R5";
            check(bad < 0, tag, (eo == ao) ? "frame drive value" : "frame drive enable",
                  (eo == ao) ? (av & eo) : ao, (eo == ao) ? (ev & eo) : eo);
        end

        if (any_rd) exp_rd = sw;
        check(rd_data == exp_rd, "R7", "read data", {48'd0, rd_data}, {48'd0, exp_rd});

        repeat (3) @(negedge clk);
        check(cmd_ack && !mdc && !busy, "R9", "ack held while request high",
              {61'd0, cmd_ack, mdc, busy}, 64'b100);
        cmd_req = 1'b0;
        @(negedge clk);
        check(!cmd_ack && !busy, "R9", "ack released", {62'd0, cmd_ack, busy}, 64'd0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: run did not complete: actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1DB5));
        repeat (4) @(negedge clk);
        check(!mdc && !mdio_oe && !cmd_ack && !busy && rd_data == 16'h0, "R1",
              "outputs in reset", {43'd0, mdc, mdio_oe, cmd_ack, busy, rd_data}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!mdc && !mdio_oe && !busy, "R1", "idle after reset",
              {61'd0, mdc, mdio_oe, busy}, 64'd0);

        // Directed corner cases
        run_cmd(1'b0, 2'b01, 5'h1F, 5'h00, 16'h0000, 16'hA5C3, 1'b0, 16'h0000); // basic write
        run_cmd(1'b0, 2'b10, 5'h03, 5'h1F, 16'h0000, 16'h0000, 1'b0, 16'hBEEF); // basic read
        run_cmd(1'b0, 2'b10, 5'h00, 5'h01, 16'h0000, 16'h0000, 1'b0, 16'hFFFF); // read all ones
        run_cmd(1'b0, 2'b01, 5'h05, 5'h02, 16'h0000, 16'h1234, 1'b0, 16'h5555); // write keeps rd_data
        run_cmd(1'b1, 2'b00, 5'h11, 5'h07, 16'hC0DE, 16'h0000, 1'b0, 16'h0000); // address only
        run_cmd(1'b1, 2'b01, 5'h02, 5'h01, 16'h8001, 16'h7E7E, 1'b1, 16'h0000); // addr + write
        run_cmd(1'b1, 2'b11, 5'h02, 5'h03, 16'h0010, 16'h0000, 1'b1, 16'h0000); // addr + read zeros
        run_cmd(1'b1, 2'b10, 5'h02, 5'h03, 16'h0000, 16'h0000, 1'b0, 16'h8001); // read-inc alone
        run_cmd(1'b1, 2'b01, 5'h1E, 5'h1D, 16'hFFFF, 16'h0001, 1'b0, 16'h0000); // write alone

        // Seeded random commands
        for (int i = 0; i < 16; i++) begin
            logic ext;
            logic [1:0] op;
            ext = 1'($urandom);
            op  = ext ? 2'($urandom) : (1'($urandom) ? 2'b10 : 2'b01);
            run_cmd(ext, op, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
                    1'($urandom), 16'($urandom));
        end

        check(hi_min == EXP_HALF && hi_max == EXP_HALF, "R2", "MDC high phase cycles",
              {32'(hi_min), 32'(hi_max)}, {32'(EXP_HALF), 32'(EXP_HALF)});
        finish_run();
    end
endmodule